// File: doc/BRIEF.md
# Serial Control Word Loader

This block is the three-wire configuration port of a two-channel frequency synthesizer controller. A host presents a serial clock, a data line and a load-enable line. The block samples them on its own system clock and shifts one data bit into a 23-bit shift register on every rising edge of the serial clock. On every rising edge of load-enable, it copies the shifted word into one of four holding banks. There is a reference bank and a feedback bank for each channel, and a two-bit code at the low end of the word picks the bank.

The banks drive the divider and phase-detector settings of each channel. A reference bank holds the reference division count, a charge-pump current select and two test bits. A feedback bank holds a monitor-output select, a prescaler modulus select, a phase polarity select, a swallow count and a program count. When a bank is written, a one-cycle strobe for that bank tells the downstream dividers to reload. The serial inputs are expected to be synchronised to the system clock already.

Top module: `serial_word_loader`

## Requirements
- R1: Each rising edge of serClk, as sampled on clk, shifts serData into bit 0 of the 23-bit shift register and moves every existing bit up by one. A word is therefore sent most significant bit first, and its last bit ends up in bit 0.
- R2: On a clock where serLoad is sampled rising, the bank captures the shift register value from before any shift taken in that same clock.
- R3: Word bits [1:0] select the bank: 00 is channel 0 reference, 01 is channel 0 feedback, 10 is channel 1 reference, 11 is channel 1 feedback.
- R4: A reference word carries the reference count in bits [15:2], the charge-pump select in bit 16 and the test field in bits [18:17].
- R5: A feedback word carries the monitor select in bit 2, the modulus select in bit 3, the phase polarity in bit 4, the swallow count in bits [11:5] and the program count in bits [22:12].
- R6: Bits [22:19] of a reference word have no effect on any output.
- R7: Bank contents change only on a load-enable rising edge and only in the selected bank. Shifting while serLoad is low, or while it is held high after the edge, leaves every output unchanged.
- R8: The strobe of the written bank (refStrobe or fbStrobe, bit = channel) is high for exactly the clock after the load edge. At most one strobe is high at a time.
- R9: While rst_n is low, all banks, strobes and the shift register are cleared to zero.
- R10: New bank values appear on the outputs in the same clock as the strobe, one clock after the load edge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock (synchronised) |
| serData | input | 1 | Serial data bit |
| serLoad | input | 1 | Load enable; its rising edge writes a bank |
| refCount | output | 28 | Reference count, 14 bits per channel |
| cpSel | output | 2 | Charge-pump current select per channel |
| testBits | output | 4 | Test field, 2 bits per channel |
| monitorSel | output | 2 | Lock/monitor output select per channel |
| modulusSel | output | 2 | Prescaler modulus select per channel |
| phasePol | output | 2 | Phase detector polarity per channel |
| swallowCount | output | 14 | Swallow count, 7 bits per channel |
| programCount | output | 22 | Program count, 11 bits per channel |
| refStrobe | output | 2 | One-cycle reference bank update strobe per channel |
| fbStrobe | output | 2 | One-cycle feedback bank update strobe per channel |

## Verification
A corrupted shift register cannot be seen at the ports until the next load edge. It then shows up as wrong field values in the selected bank, one clock after that edge. A wrong bank decode or a wrong edge detector shows up in that same clock as a strobe on the wrong bank, a missing strobe, or a change in a bank that was not addressed. Because the bench runs a behavioural model alongside the design and compares every field and strobe on every clock, any such fault is reported at the first clock where the outputs differ.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int CODE_W  = 2;
  localparam int REF_W   = 14;
  localparam int TEST_W  = 2;
  localparam int MODE_W  = 3;
  localparam int SWAL_W  = 7;
  localparam int PROG_W  = 11;
  localparam int WORD_W  = CODE_W + MODE_W + SWAL_W + PROG_W;
  localparam int REFV_W  = REF_W + 1 + TEST_W;
  localparam int FBV_W   = MODE_W + SWAL_W + PROG_W;
  localparam int NUM_CH  = 2 ** (CODE_W - 1);

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } swl_ctrl_t;
endpackage

// File: rtl/swl_ctrl.sv
module swl_ctrl
  import swl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      serClk,
  input  logic      serLoad,
  output swl_ctrl_t ctrl
);
  logic serClkQ;
  logic serLoadQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serClkQ  <= 1'b0;
      serLoadQ <= 1'b0;
    end else begin
      serClkQ  <= serClk;
      serLoadQ <= serLoad;
    end
  end

  always_comb begin
    ctrl.shiftEn = serClk & ~serClkQ;
    ctrl.loadEn  = serLoad & ~serLoadQ;
  end
endmodule

// File: rtl/swl_channel_bank.sv
module swl_channel_bank
  import swl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadRef,
  input  logic              loadFb,
  input  logic [REFV_W-1:0] refVal,
  input  logic [FBV_W-1:0]  fbVal,
  output logic [REF_W-1:0]  refCount,
  output logic              cpSel,
  output logic [TEST_W-1:0] testBits,
  output logic              monitorSel,
  output logic              modulusSel,
  output logic              phasePol,
  output logic [SWAL_W-1:0] swallowCount,
  output logic [PROG_W-1:0] programCount,
  output logic              refStrobe,
  output logic              fbStrobe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refCount <= '0;
      cpSel    <= 1'b0;
      testBits <= '0;
    end else if (loadRef) begin
      refCount <= refVal[REF_W-1:0];
      cpSel    <= refVal[REF_W];
      testBits <= refVal[REF_W+1 +: TEST_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      monitorSel   <= 1'b0;
      modulusSel   <= 1'b0;
      phasePol     <= 1'b0;
      swallowCount <= '0;
      programCount <= '0;
    end else if (loadFb) begin
      monitorSel   <= fbVal[0];
      modulusSel   <= fbVal[1];
      phasePol     <= fbVal[2];
      swallowCount <= fbVal[MODE_W +: SWAL_W];
      programCount <= fbVal[MODE_W+SWAL_W +: PROG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refStrobe <= 1'b0;
      fbStrobe  <= 1'b0;
    end else begin
      refStrobe <= loadRef;
      fbStrobe  <= loadFb;
    end
  end
endmodule

// File: rtl/swl_datapath.sv
module swl_datapath
  import swl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     serData,
  input  swl_ctrl_t                ctrl,
  output logic [NUM_CH*REF_W-1:0]  refCount,
  output logic [NUM_CH-1:0]        cpSel,
  output logic [NUM_CH*TEST_W-1:0] testBits,
  output logic [NUM_CH-1:0]        monitorSel,
  output logic [NUM_CH-1:0]        modulusSel,
  output logic [NUM_CH-1:0]        phasePol,
  output logic [NUM_CH*SWAL_W-1:0] swallowCount,
  output logic [NUM_CH*PROG_W-1:0] programCount,
  output logic [NUM_CH-1:0]        refStrobe,
  output logic [NUM_CH-1:0]        fbStrobe
);
  localparam int CHSEL_W = CODE_W - 1;

  logic [WORD_W-1:0]  shiftReg;
  logic               isFbWord;
  logic [CHSEL_W-1:0] chSel;
  logic [REFV_W-1:0]  refVal;
  logic [FBV_W-1:0]   fbVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (ctrl.shiftEn) begin
      shiftReg <= {shiftReg[WORD_W-2:0], serData};
    end
  end

  always_comb begin
    isFbWord = shiftReg[0];
    chSel    = shiftReg[CODE_W-1:1];
    refVal   = shiftReg[CODE_W +: REFV_W];
    fbVal    = shiftReg[CODE_W +: FBV_W];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic loadRef;
    logic loadFb;
    logic hit;

    always_comb begin
      hit     = ctrl.loadEn && (chSel == CHSEL_W'(c));
      loadRef = hit && !isFbWord;
      loadFb  = hit && isFbWord;
    end

    swl_channel_bank i_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .loadRef      (loadRef),
      .loadFb       (loadFb),
      .refVal       (refVal),
      .fbVal        (fbVal),
      .refCount     (refCount[c*REF_W +: REF_W]),
      .cpSel        (cpSel[c]),
      .testBits     (testBits[c*TEST_W +: TEST_W]),
      .monitorSel   (monitorSel[c]),
      .modulusSel   (modulusSel[c]),
      .phasePol     (phasePol[c]),
      .swallowCount (swallowCount[c*SWAL_W +: SWAL_W]),
      .programCount (programCount[c*PROG_W +: PROG_W]),
      .refStrobe    (refStrobe[c]),
      .fbStrobe     (fbStrobe[c])
    );
  end
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader
  import swl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     serClk,
  input  logic                     serData,
  input  logic                     serLoad,
  output logic [NUM_CH*REF_W-1:0]  refCount,
  output logic [NUM_CH-1:0]        cpSel,
  output logic [NUM_CH*TEST_W-1:0] testBits,
  output logic [NUM_CH-1:0]        monitorSel,
  output logic [NUM_CH-1:0]        modulusSel,
  output logic [NUM_CH-1:0]        phasePol,
  output logic [NUM_CH*SWAL_W-1:0] swallowCount,
  output logic [NUM_CH*PROG_W-1:0] programCount,
  output logic [NUM_CH-1:0]        refStrobe,
  output logic [NUM_CH-1:0]        fbStrobe
);
  swl_ctrl_t ctrl;

  swl_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .serClk  (serClk),
    .serLoad (serLoad),
    .ctrl    (ctrl)
  );

  swl_datapath i_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .serData      (serData),
    .ctrl         (ctrl),
    .refCount     (refCount),
    .cpSel        (cpSel),
    .testBits     (testBits),
    .monitorSel   (monitorSel),
    .modulusSel   (modulusSel),
    .phasePol     (phasePol),
    .swallowCount (swallowCount),
    .programCount (programCount),
    .refStrobe    (refStrobe),
    .fbStrobe     (fbStrobe)
  );
endmodule

// File: rtl/swl_checker.sv
module swl_checker
  import swl_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     serLoad,
  input logic [NUM_CH*REF_W-1:0]  refCount,
  input logic [NUM_CH-1:0]        cpSel,
  input logic [NUM_CH*TEST_W-1:0] testBits,
  input logic [NUM_CH-1:0]        monitorSel,
  input logic [NUM_CH-1:0]        modulusSel,
  input logic [NUM_CH-1:0]        phasePol,
  input logic [NUM_CH*SWAL_W-1:0] swallowCount,
  input logic [NUM_CH*PROG_W-1:0] programCount,
  input logic [NUM_CH-1:0]        refStrobe,
  input logic [NUM_CH-1:0]        fbStrobe
);
  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({refStrobe, fbStrobe}));

  // R10
  load_gives_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serLoad) |=> (|{refStrobe, fbStrobe}));

  // R7
  no_load_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !serLoad |=> !(|{refStrobe, fbStrobe}));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !refStrobe[c] |-> $stable({refCount[c*REF_W +: REF_W], cpSel[c],
                                 testBits[c*TEST_W +: TEST_W]}));
    // R7
    fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fbStrobe[c] |-> $stable({monitorSel[c], modulusSel[c], phasePol[c],
                                swallowCount[c*SWAL_W +: SWAL_W],
                                programCount[c*PROG_W +: PROG_W]}));
  end
endmodule

bind serial_word_loader swl_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .serLoad      (serLoad),
  .refCount     (refCount),
  .cpSel        (cpSel),
  .testBits     (testBits),
  .monitorSel   (monitorSel),
  .modulusSel   (modulusSel),
  .phasePol     (phasePol),
  .swallowCount (swallowCount),
  .programCount (programCount),
  .refStrobe    (refStrobe),
  .fbStrobe     (fbStrobe)
);

// File: tb/test_serial_word_loader.sv
`timescale 1ns/1ps
module test_serial_word_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serLoad = 1'b0;

  logic [27:0] refCount;
  logic [1:0]  cpSel;
  logic [3:0]  testBits;
  logic [1:0]  monitorSel, modulusSel, phasePol;
  logic [13:0] swallowCount;
  logic [21:0] programCount;
  logic [1:0]  refStrobe, fbStrobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  serial_word_loader i_serial_word_loader (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .refCount(refCount), .cpSel(cpSel), .testBits(testBits),
    .monitorSel(monitorSel), .modulusSel(modulusSel), .phasePol(phasePol),
    .swallowCount(swallowCount), .programCount(programCount),
    .refStrobe(refStrobe), .fbStrobe(fbStrobe)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mSh, mPc, mPl;
  int mRefF[2];
  int mFbF[2];
  int mStb;

  always @(posedge clk) begin
    if (!rst_n) begin
      mSh = 0; mPc = 0; mPl = 0; mStb = 0;
      for (int k = 0; k < 2; k++) begin mRefF[k] = 0; mFbF[k] = 0; end
    end else begin
      mStb = 0;
      if (serLoad && mPl == 0) begin
        int ch;
        ch = (mSh >> 1) & 1;
        if ((mSh & 1) == 0) begin
          mRefF[ch] = (mSh >> 2) % (1 << 17);
          mStb = 1 << ch;
        end else begin
          mFbF[ch] = (mSh >> 2) % (1 << 21);
          mStb = 1 << (ch + 2);
        end
      end
      if (serClk && mPc == 0) mSh = ((mSh * 2) + int'(serData)) % (1 << 23);
      mPc = int'(serClk);
      mPl = int'(serLoad);
    end
  end

  function automatic int dutRef(input int ch);
    return (int'(testBits[ch*2 +: 2]) << 15) | (int'(cpSel[ch]) << 14) |
           int'(refCount[ch*14 +: 14]);
  endfunction

  function automatic int dutFb(input int ch);
    return (int'(programCount[ch*11 +: 11]) << 10) | (int'(swallowCount[ch*7 +: 7]) << 3) |
           (int'(phasePol[ch]) << 2) | (int'(modulusSel[ch]) << 1) | int'(monitorSel[ch]);
  endfunction

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        check("R4 ref bank vs model", dutRef(k), mRefF[k]);
        check("R5 fb bank vs model", dutFb(k), mFbF[k]);
      end
      check("R8 strobes vs model", int'({fbStrobe, refStrobe}), mStb);
    end
  end

  task automatic shiftBit(input logic b);
    @(negedge clk); serData = b; serClk = 1'b1;
    @(negedge clk); serClk = 1'b0;
  endtask

  task automatic shiftWord(input logic [22:0] w);
    for (int i = 22; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic pulseLoad(input int expStb);
    @(negedge clk); serLoad = 1'b1;
    @(negedge clk);
    check("R10 strobe after load edge", int'({fbStrobe, refStrobe}), expStb);
    serLoad = 1'b0;
    @(negedge clk);
    check("R8 strobe lasts one cycle", int'({fbStrobe, refStrobe}), 0);
  endtask

  function automatic logic [22:0] refWord(input int code, input int rc, input int cp,
                                          input int tb, input int junk);
    return 23'((junk << 19) | (tb << 17) | (cp << 16) | (rc << 2) | code);
  endfunction

  function automatic logic [22:0] fbWord(input int code, input int md, input int sw,
                                         input int pg);
    return 23'((pg << 12) | (sw << 5) | (md << 2) | code);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset refCount", int'(refCount), 0);
    check("R9 reset programCount", int'(programCount), 0);
    check("R9 reset strobes", int'({fbStrobe, refStrobe}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R6: channel 0 reference, unused high bits set
    shiftWord(refWord(0, 'h1234, 1, 2, 'hB));
    pulseLoad(1);
    check("R4 ch0 refCount", int'(refCount[13:0]), 'h1234);
    check("R4 ch0 cpSel", int'(cpSel[0]), 1);
    check("R6 ch0 testBits", int'(testBits[1:0]), 2);
    check("R6 ch0 fb untouched", dutFb(0), 0);

    // R3 R5: channel 0 feedback
    shiftWord(fbWord(1, 5, 'h55, 'h5A3));
    pulseLoad(4);
    check("R5 ch0 monitorSel", int'(monitorSel[0]), 1);
    check("R5 ch0 modulusSel", int'(modulusSel[0]), 0);
    check("R5 ch0 phasePol", int'(phasePol[0]), 1);
    check("R5 ch0 swallow", int'(swallowCount[6:0]), 'h55);
    check("R1 ch0 program", int'(programCount[10:0]), 'h5A3);

    // R3: channel 1 reference (maximum count) and feedback (all ones)
    shiftWord(refWord(2, 'h3FFF, 0, 1, 0));
    pulseLoad(2);
    check("R3 ch1 refCount", int'(refCount[27:14]), 'h3FFF);
    check("R3 ch0 ref kept", int'(refCount[13:0]), 'h1234);
    shiftWord(fbWord(3, 2, 'h7F, 'h7FF));
    pulseLoad(8);
    check("R3 ch1 program", int'(programCount[21:11]), 'h7FF);
    check("R3 ch1 mode", int'({phasePol[1], modulusSel[1], monitorSel[1]}), 2);

    // R7: shifting with load low changes nothing
    shiftWord(refWord(0, 'h0AAA, 0, 0, 0));
    check("R7 shift without load", int'(refCount[13:0]), 'h1234);

    // R7: load held high across shifting; only one edge counts
    @(negedge clk); serLoad = 1'b1;
    @(negedge clk);
    check("R7 first edge loads", int'(refCount[13:0]), 'h0AAA);
    shiftWord(refWord(0, 'h0555, 1, 3, 0));
    check("R7 held load no reload", int'(refCount[13:0]), 'h0AAA);
    @(negedge clk); serLoad = 1'b0;
    pulseLoad(1);
    check("R7 new edge reloads", int'(refCount[13:0]), 'h0555);

    // R2: load edge and shift edge in the same clock
    shiftWord(fbWord(3, 1, 'h12, 'h321));
    @(negedge clk); serLoad = 1'b1; serClk = 1'b1; serData = 1'b0;
    @(negedge clk); serClk = 1'b0; serLoad = 1'b0;
    check("R2 load sees pre-shift word", int'(programCount[21:11]), 'h321);
    check("R2 swallow pre-shift", int'(swallowCount[13:7]), 'h12);
    repeat (2) @(negedge clk);

    // R9: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid-run reset banks", int'(refCount) | int'(programCount), 0);
    check("R9 mid-run reset fields", int'({cpSel, testBits, swallowCount}), 0);
    rst_n = 1'b1;
    // shift register cleared: loading without shifting writes zeros to ch0 ref
    pulseLoad(1);
    check("R9 shift register cleared", dutRef(0), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule